// File: doc/BRIEF.md
# Reconfigurable Execution Fabric Unit

This block takes the place of the ALU in the execute stage of a 32-bit in-order pipeline. Each issued instruction delivers two 32-bit register values and an 8-bit immediate taken from a side field of the instruction word. The unit returns one 32-bit value for the destination register. The upper four bits of the immediate choose one of a fixed set of resident sub-operations. The lower four bits carry inline data for the chosen sub-operation. This fixed set stands in for a loaded configuration.

The unit keeps a little state from one instruction to the next. A latch sub-operation stores both operands, so that a later sub-operation can combine four values. A carry-less multiplier runs over several cycles in the background. Software fills the wait with bubble instructions, or with unrelated work, and then collects the two product halves with separate read instructions. The result of every issued instruction is registered and appears one cycle after issue.

Top module: `fab_exec`

## Requirements
- R1: When `rst` is high on a clock edge, the unit clears `res_valid`, `res_data`, `mul_busy`, both latched operands and the stored product to zero. After reset, a low or high product read therefore returns 0, and a four-input XOR returns `src_a ^ src_b`.
- R2: An instruction issued with `issue_valid` high on edge k yields `res_valid` = 1 with its result after edge k. With no issue, `res_valid` and `res_data` are 0 after the edge, and no latched operand or stored product changes.
- R3: The opcode is `imm[7:4]` and the inline data is `imm[3:0]`. The opcodes are: 0x0 latch, 0x1 four-input XOR, 0x2 rotate, 0x3 multiply start, 0x4 bubble, 0x5 product low read, 0x6 product high read.
- R4: Opcode 0x0 stores `src_a` and `src_b` as the latched pair and returns 0.
- R5: Opcode 0x1 returns latched A ^ latched B ^ `src_a` ^ `src_b`. The latched pair does not change.
- R6: Opcode 0x2 returns `src_a` rotated left by the 5-bit amount `{imm[3:0], src_b[0]}`.
- R7: Opcode 0x3 starts a 32x32 carry-less (GF(2) polynomial) multiply of `src_a` by `src_b` and returns 0. `mul_busy` is 1 during the four cycles that follow the start edge, and the new 64-bit product is stored on the fourth edge after the start. A start issued while busy abandons the running multiply and begins again with the new operands.
- R8: Opcode 0x5 returns bits [31:0] of the stored product, and opcode 0x6 returns bits [63:32]. A read issued while `mul_busy` is 1 returns the previously stored product.
- R9: Opcode 0x4 (bubble) returns 0 and changes no state.
- R10: Opcodes 0x7 to 0xF return 0 and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| imm | input | 8 | Sub-operation select [7:4] and inline data [3:0] |
| res_valid | output | 1 | Result of the instruction issued in the previous cycle |
| res_data | output | 32 | Result value for the destination register |
| mul_busy | output | 1 | Carry-less multiply in progress |

## Verification
Two events can meet on the same edge: the multiplier storing its product, and a product read or a new multiply start. The bench issues a read in the last busy cycle, which must return the old product. It also issues a start in that cycle, which must discard the pending product and restart the count. A behavioural model computes each product in one step and applies the four-cycle delay with a plain counter. The bench compares result, valid and busy against this model on every clock, during directed sequences and a long random opcode stream.

// File: rtl/fab_pkg.sv
package fab_pkg;

    localparam int FAB_DW = 32;

    typedef enum logic [3:0] {
        OP_LATCH  = 4'h0,
        OP_XOR4   = 4'h1,
        OP_ROTL   = 4'h2,
        OP_MSTART = 4'h3,
        OP_BUBBLE = 4'h4,
        OP_RDLO   = 4'h5,
        OP_RDHI   = 4'h6
    } fab_op_e;

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] dat;
    } fab_imm_t;

    function automatic logic is_data_op(input logic [3:0] code);
        return (code == OP_XOR4) || (code == OP_ROTL) ||
               (code == OP_RDLO) || (code == OP_RDHI);
    endfunction

endpackage

// File: rtl/fab_oplatch.sv
module fab_oplatch #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic [DW-1:0] held_a,
    output logic [DW-1:0] held_b
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_a <= '0;
            held_b <= '0;
        end else if (load) begin
            held_a <= in_a;
            held_b <= in_b;
        end
    end
endmodule

// File: rtl/fab_rotl.sv
module fab_rotl #(
    parameter int DW = 32,
    localparam int SH_W = $clog2(DW)
) (
    input  logic [DW-1:0]   val,
    input  logic [SH_W-1:0] amt,
    output logic [DW-1:0]   rotated
);
    logic [2*DW-1:0] doubled;

    always_comb begin
        doubled = {val, val} << amt;
        rotated = doubled[2*DW-1:DW];
    end
endmodule

// File: rtl/fab_clmul_seq.sv
module fab_clmul_seq #(
    parameter int DW    = 32,
    parameter int STEPS = 4,
    localparam int BPS   = DW / STEPS,
    localparam int CNT_W = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic [2*DW-1:0] product,
    output logic          busy
);
    logic [2*DW-1:0] acc;
    logic [2*DW-1:0] mcand;
    logic [DW-1:0]   mplier;
    logic [CNT_W-1:0] cnt;
    logic [2*DW-1:0] partial;

    always_comb begin
        partial = acc;
        for (int i = 0; i < BPS; i++) begin
            if (mplier[i]) partial = partial ^ (mcand << i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            mcand   <= '0;
            mplier  <= '0;
            cnt     <= '0;
            product <= '0;
        end else if (start) begin
            acc    <= '0;
            mcand  <= {{DW{1'b0}}, op_a};
            mplier <= op_b;
            cnt    <= CNT_W'(STEPS);
        end else if (cnt != '0) begin
            acc    <= partial;
            mcand  <= mcand << BPS;
            mplier <= mplier >> BPS;
            cnt    <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) product <= partial;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/fab_exec.sv
module fab_exec
    import fab_pkg::*;
#(
    parameter int DW    = FAB_DW,
    parameter int STEPS = 4,
    localparam int SH_W = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue_valid,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [7:0]    imm,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic          mul_busy
);
    fab_imm_t        imm_f;
    fab_op_e         op;
    logic [DW-1:0]   lat_a, lat_b, rot_out, res_next;
    logic [2*DW-1:0] prod;
    logic [SH_W-1:0] rot_amt;
    logic            do_latch, do_mstart;

    assign imm_f     = imm;
    assign op        = fab_op_e'(imm_f.op);
    assign rot_amt   = SH_W'({imm_f.dat, src_b[0]});
    assign do_latch  = issue_valid && (op == OP_LATCH);
    assign do_mstart = issue_valid && (op == OP_MSTART);

    fab_oplatch #(.DW(DW)) u_latch (
        .clk(clk), .rst(rst), .load(do_latch),
        .in_a(src_a), .in_b(src_b),
        .held_a(lat_a), .held_b(lat_b)
    );

    fab_rotl #(.DW(DW)) u_rot (
        .val(src_a), .amt(rot_amt), .rotated(rot_out)
    );

    fab_clmul_seq #(.DW(DW), .STEPS(STEPS)) u_mul (
        .clk(clk), .rst(rst), .start(do_mstart),
        .op_a(src_a), .op_b(src_b),
        .product(prod), .busy(mul_busy)
    );

    always_comb begin
        case (op)
            OP_XOR4: res_next = lat_a ^ lat_b ^ src_a ^ src_b;
            OP_ROTL: res_next = rot_out;
            OP_RDLO: res_next = prod[DW-1:0];
            OP_RDHI: res_next = prod[2*DW-1:DW];
            default: res_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= issue_valid;
            res_data  <= issue_valid ? res_next : '0;
        end
    end
endmodule

// File: rtl/fab_exec_chk.sv
module fab_exec_chk
    import fab_pkg::*;
#(
    parameter int DW    = FAB_DW,
    parameter int STEPS = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          issue_valid,
    input logic [7:0]    imm,
    input logic          res_valid,
    input logic [DW-1:0] res_data,
    input logic          mul_busy
);
    int unsigned since_start;

    always_ff @(posedge clk) begin
        if (rst) since_start <= 0;
        else if (issue_valid && imm[7:4] == OP_MSTART) since_start <= STEPS;
        else if (since_start != 0) since_start <= since_start - 1;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && res_data == '0 && !mul_busy));

    assert_valid_follows_issue_R2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> res_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> (!res_valid && res_data == '0));

    assert_nondata_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !is_data_op(imm[7:4])) |=> res_data == '0);

    assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && imm[7:4] == OP_MSTART) |=> mul_busy);

    assert_busy_window_R7: assert property (@(posedge clk) disable iff (rst)
        mul_busy == (since_start != 0));
endmodule

bind fab_exec fab_exec_chk #(.DW(DW), .STEPS(STEPS)) u_chk (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .imm(imm),
    .res_valid(res_valid), .res_data(res_data), .mul_busy(mul_busy)
);

// File: tb/fab_exec_tb.sv
module fab_exec_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [7:0]  imm = '0;
    logic        res_valid;
    logic [31:0] res_data;
    logic        mul_busy;

    int checks = 0;
    int errs   = 0;
    string cur_tag = "R1";
    string chk_tag = "R1";

    always #4 clk = ~clk;

    fab_exec u_dut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .res_valid(res_valid), .res_data(res_data), .mul_busy(mul_busy)
    );

    // behavioural reference
    logic [31:0] m_la, m_lb, m_data;
    logic [63:0] m_prod, m_pend;
    logic        m_valid;
    int          m_cnt;

    function automatic logic [63:0] clmul(input logic [31:0] a, input logic [31:0] b);
        logic [63:0] r = '0;
        for (int i = 0; i < 32; i++) if (b[i]) r = r ^ ({32'b0, a} << i);
        return r;
    endfunction

    function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int i = 0; i < n; i++) r = {r[30:0], r[31]};
        return r;
    endfunction

    always @(posedge clk) begin
        chk_tag = cur_tag;
        if (rst) begin
            m_la = '0; m_lb = '0; m_prod = '0; m_pend = '0;
            m_cnt = 0; m_valid = 1'b0; m_data = '0;
        end else begin
            logic start;
            start   = issue_valid && imm[7:4] == 4'h3;
            m_valid = issue_valid;
            m_data  = '0;
            if (issue_valid) begin
                case (imm[7:4])
                    4'h0: begin m_la = src_a; m_lb = src_b; end
                    4'h1: m_data = m_la ^ m_lb ^ src_a ^ src_b;
                    4'h2: m_data = rotl(src_a, int'({imm[3:0], src_b[0]}));
                    4'h5: m_data = m_prod[31:0];
                    4'h6: m_data = m_prod[63:32];
                    default: m_data = '0;
                endcase
            end
            if (start) begin
                m_pend = clmul(src_a, src_b);
                m_cnt  = 4;
            end else if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) m_prod = m_pend;
            end
        end
    end

    always @(negedge clk) begin
        checks++;
        if (res_valid !== m_valid || res_data !== m_data || mul_busy !== (m_cnt != 0)) begin
            errs++;
            $display("FAIL %s: valid/data/busy actual %b/%h/%b expected %b/%h/%b",
                     chk_tag, res_valid, res_data, mul_busy, m_valid, m_data, (m_cnt != 0));
        end
    end

    task automatic issue(input logic [3:0] op, input logic [3:0] dat,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        issue_valid = 1'b1; imm = {op, dat}; src_a = a; src_b = b; cur_tag = tag;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_valid = 1'b0; imm = '0; src_a = '0; src_b = '0; cur_tag = tag;
        end
    endtask

    // direct check of the result of the instruction just issued
    task automatic expect_res(input logic [31:0] exp, input string tag);
        @(negedge clk);
        issue_valid = 1'b0; imm = '0; cur_tag = tag;
        #1;
        checks++;
        if (res_data !== exp || res_valid !== 1'b1) begin
            errs++;
            $display("FAIL %s: direct result actual %h expected %h", tag, res_data, exp);
        end
    endtask

    initial begin
        #400000;
        errs++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: product and latches zero after reset
        issue(4'h5, 4'h0, 32'h0, 32'h0, "R1");
        expect_res(32'h0, "R1");
        issue(4'h6, 4'h0, 32'h0, 32'h0, "R1");
        expect_res(32'h0, "R1");
        issue(4'h1, 4'h0, 32'hA5A5_0000, 32'h0000_5A5A, "R1");
        expect_res(32'hA5A5_5A5A, "R1");
        // R4 and R5: latch then four-input XOR
        issue(4'h0, 4'h0, 32'h1234_5678, 32'h0F0F_0F0F, "R4");
        expect_res(32'h0, "R4");
        issue(4'h1, 4'h0, 32'hFFFF_0000, 32'h0000_00FF, "R5");
        expect_res(32'h1234_5678 ^ 32'h0F0F_0F0F ^ 32'hFFFF_0000 ^ 32'h0000_00FF, "R5");
        // R6: rotate amounts from the edges of the 5-bit range
        issue(4'h2, 4'h0, 32'h8000_0001, 32'h1, "R6");
        expect_res(32'h0000_0003, "R6");
        issue(4'h2, 4'hF, 32'h8000_0001, 32'h1, "R6");
        expect_res(32'hC000_0000, "R6");
        issue(4'h2, 4'h0, 32'hDEAD_BEEF, 32'h2, "R6");
        expect_res(32'hDEAD_BEEF, "R6");
        // R7 and R8: 3 x 3 carry-less is 5; early read gives old product
        issue(4'h3, 4'h0, 32'h3, 32'h3, "R7");
        issue(4'h5, 4'h0, 32'h0, 32'h0, "R8");
        expect_res(32'h0, "R8");
        issue(4'h4, 4'h0, 32'h0, 32'h0, "R9");
        issue(4'h4, 4'h0, 32'h0, 32'h0, "R9");
        idle(1, "R7");
        issue(4'h5, 4'h0, 32'h0, 32'h0, "R8");
        expect_res(32'h5, "R8");
        // read in the completing cycle, then next cycle
        issue(4'h3, 4'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7");
        idle(3, "R7");
        issue(4'h6, 4'h0, 32'h0, 32'h0, "R8");
        expect_res(32'h0, "R8");
        issue(4'h6, 4'h0, 32'h0, 32'h0, "R8");
        expect_res(32'h5555_5555, "R8");
        issue(4'h5, 4'h0, 32'h0, 32'h0, "R8");
        expect_res(32'h5555_5555, "R8");
        // R7: restart in the completing cycle discards the pending product
        issue(4'h3, 4'h0, 32'h7, 32'h7, "R7");
        idle(3, "R7");
        issue(4'h3, 4'h0, 32'h2, 32'h2, "R7");
        issue(4'h5, 4'h0, 32'h0, 32'h0, "R7");
        expect_res(32'h5555_5555, "R7");
        idle(4, "R7");
        issue(4'h5, 4'h0, 32'h0, 32'h0, "R7");
        expect_res(32'h4, "R7");
        // R10: unknown opcodes leave latches and product alone
        for (int k = 7; k < 16; k++) begin
            issue(4'(k), 4'(k), 32'hCAFE_0000 + k, 32'h0BAD_0000 + k, "R10");
            expect_res(32'h0, "R10");
        end
        issue(4'h1, 4'h0, 32'h0, 32'h0, "R10");
        expect_res(32'h1234_5678 ^ 32'h0F0F_0F0F, "R10");
        issue(4'h5, 4'h0, 32'h0, 32'h0, "R10");
        expect_res(32'h4, "R10");
        // R2 and R3: random stream with gaps, model compared each clock
        for (int k = 0; k < 2000; k++) begin
            if ($urandom_range(0, 3) == 0) idle(1, "R2");
            else issue(4'($urandom_range(0, 15)), 4'($urandom), $urandom, $urandom, "R3");
        end
        idle(8, "R2");
        // R1: reset mid-operation
        issue(4'h3, 4'h0, 32'hFFFF, 32'hFFFF, "R1");
        @(negedge clk); rst = 1'b1; issue_valid = 1'b0; cur_tag = "R1";
        @(negedge clk); rst = 1'b0;
        issue(4'h6, 4'h0, 32'h0, 32'h0, "R1");
        expect_res(32'h0, "R1");
        idle(6, "R1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule